// File: doc/BRIEF.md
# Host-Supervised Motion Safety Controller

This block guards a motion-control card that a remote host drives over a network link. It steps through five session states in a fixed order. It keeps a watchdog that the host must feed with every process-data write. From these two it decides whether the general outputs may follow host commands and whether the step generators may run. Outside the operating state, every output is held safe and the step generators are told to stop.

Bring-up is a sequence of host commands. A header request opens the session, and a reset command clears the step-generator position counters through a one-cycle clear pulse. The step generators then acknowledge the clear, and the first process-data write after that acknowledgement starts operation. If the watchdog runs out, the block drops into an expired state and halts motion. The halt is either immediate or a controlled deceleration that ends when the step generators report completion. Writing process data again does not leave the expired state; only a fresh reset command does, followed by the same acknowledgement and first write.

The timeout comes from a limit input, counted in clock cycles. A limit of zero selects a built-in default derived from the clock frequency and a timeout in microseconds, which is 75,000 cycles at 50 MHz and 1500 µs.

Top module: `motion_safety_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the block is in IDLE (`state_code` 0) with `out_enable` 0, `step_enable` 0, `hard_stop` 1, `soft_stop` 0 and `cnt_clear` 0.
- R2: State codes are IDLE=0, INIT=1, RESET=2, ACTIVE=3, EXPIRED=4. `cmd_header` moves IDLE to INIT, and an accepted `cmd_reset` moves the block to RESET.
- R3: Each accepted `cmd_reset` raises `cnt_clear` for exactly one cycle: the first cycle in RESET. A reset command while already in RESET pulses the clear again and discards any earlier acknowledgement.
- R4: RESET moves to ACTIVE only on a `cmd_pet` that arrives after `clr_ack` was seen high in RESET since the latest clear. A pet before that acknowledgement leaves the block in RESET.
- R5: Commands outside their state have no effect. `cmd_header` counts only in IDLE, `cmd_reset` only in INIT, RESET and EXPIRED, and `cmd_pet` only in RESET and ACTIVE.
- R6: In ACTIVE, `out_enable` and `step_enable` are 1 and both stop requests are 0. In every other state `out_enable` is 0.
- R7: In ACTIVE the state becomes EXPIRED exactly L cycles after the last accepted pet, or after entry to ACTIVE, if no further pet arrives. L is `wd_limit`, or the default (CLK_HZ/1e6·TIMEOUT_US) when `wd_limit` is 0.
- R8: In EXPIRED, `cmd_pet` is ignored. Only an accepted `cmd_reset` leaves, and it goes to RESET.
- R9: With `soft_mode` 0 at expiry, `step_enable` falls to 0 and `hard_stop` rises to 1 in the first cycle of EXPIRED.
- R10: With `soft_mode` 1 at expiry, `soft_stop` and `step_enable` stay 1 from the first EXPIRED cycle until `stop_done` is sampled high. In the next cycle, `soft_stop` and `step_enable` are 0 and `hard_stop` is 1.
- R11: A reset command accepted during a soft stop ends the soft stop at once, with `soft_stop` 0, `hard_stop` 1 and state RESET.
- R12: Asserting `rst` at any point returns the block to IDLE on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_header | input | 1 | Host header-request strobe |
| cmd_reset | input | 1 | Host reset-command strobe |
| cmd_pet | input | 1 | Host process-data write, which also feeds the watchdog |
| clr_ack | input | 1 | Step generators confirm the counter clear |
| soft_mode | input | 1 | 1 selects decelerating stop on expiry, 0 selects immediate stop |
| stop_done | input | 1 | Step generators report the soft stop has finished |
| wd_limit | input | TMR_W | Watchdog timeout in cycles; 0 selects the default |
| state_code | output | 3 | Current session state code |
| out_enable | output | 1 | General outputs may follow commands (0 = safe state) |
| step_enable | output | 1 | Step generators may run |
| cnt_clear | output | 1 | One-cycle position-counter clear |
| hard_stop | output | 1 | Immediate stop request to the step generators |
| soft_stop | output | 1 | Decelerating stop request to the step generators |

## Verification
The bench sweeps every small timeout value, zero included, under both stop modes. For each one it measures the cycles from the last feed to expiry. A counter off by one would make that count differ from the limit, and a block that ignored the zero-selects-default rule would expire at once or never. It feeds the watchdog while expired and expects no return to operation, which catches a design that lets motion resume on feeding alone. It also sends a process-data write before the clear acknowledgement, and a second reset after an acknowledgement, to catch a design that enters operation with counters that were never confirmed clear. Soft stops are checked both with the completion handshake and with a reset that cuts them short. A stop block that dropped the enable too early, or never released it, shows up there.

// File: rtl/msc_pkg.sv
package msc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INIT   = 3'd1,
    ST_RESET  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_BITTEN = 3'd4
  } sess_t;

  // Timeout in cycles: the programmed limit, or the default when it is zero.
  function automatic logic [31:0] pick_limit(input logic [31:0] lim, input logic [31:0] dflt);
    return (lim == 32'd0) ? dflt : lim;
  endfunction

  // True when the cycle holding this count is the last one before expiry.
  function automatic logic wd_due(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

  // Step generators run in operation, or while a soft stop is in progress.
  function automatic logic step_gate(input sess_t st, input logic soft_busy);
    return (st == ST_ACTIVE) || soft_busy;
  endfunction

endpackage

// File: rtl/msc_watchdog.sv
module msc_watchdog
  import msc_pkg::*;
#(
  parameter int TMR_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             feed,
  input  logic [TMR_W-1:0] limit,
  output logic             expire,
  output logic [TMR_W-1:0] count
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || feed) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign count  = cnt_q;
  assign expire = run && !feed && wd_due(32'(cnt_q), 32'(limit));

endmodule

// File: rtl/msc_seq.sv
module msc_seq
  import msc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_header,
  input  logic  cmd_reset,
  input  logic  cmd_pet,
  input  logic  clr_ack,
  input  logic  wd_expire,
  output sess_t state,
  output logic  cnt_clear,
  output logic  reset_acc,
  output logic  enter_active,
  output logic  pet_acc
);

  sess_t st_q, st_d;
  logic  ack_seen_q;
  logic  clear_q;
  logic  hdr_acc;

  assign hdr_acc      = cmd_header && (st_q == ST_IDLE);
  assign reset_acc    = cmd_reset && ((st_q == ST_INIT) || (st_q == ST_RESET) || (st_q == ST_BITTEN));
  assign enter_active = cmd_pet && (st_q == ST_RESET) && ack_seen_q && !reset_acc;
  assign pet_acc      = cmd_pet && (st_q == ST_ACTIVE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (hdr_acc) st_d = ST_INIT;
      ST_INIT:   if (reset_acc) st_d = ST_RESET;
      ST_RESET:  if (enter_active) st_d = ST_ACTIVE;
      ST_ACTIVE: if (wd_expire) st_d = ST_BITTEN;
      ST_BITTEN: if (reset_acc) st_d = ST_RESET;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      clear_q    <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      clear_q <= reset_acc;
      if (reset_acc)                         ack_seen_q <= 1'b0;
      else if (clr_ack && st_q == ST_RESET)  ack_seen_q <= 1'b1;
      else if (st_q != ST_RESET)             ack_seen_q <= 1'b0;
    end
  end

  assign state     = st_q;
  assign cnt_clear = clear_q;

  AST_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |-> (state == ST_RESET)); // R3
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cnt_clear && !cmd_reset) |=> !cnt_clear); // R3
  AST_NO_SKIP_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_ACTIVE) && (state != ST_RESET)) |=> (state != ST_ACTIVE)); // R4
  AST_ACK_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_RESET) && !ack_seen_q) |=> (state != ST_ACTIVE)); // R4
  AST_BITTEN_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITTEN) |=> ((state == ST_BITTEN) || (state == ST_RESET))); // R8

endmodule

// File: rtl/msc_stop.sv
module msc_stop
  import msc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  sess_t state,
  input  logic  wd_expire,
  input  logic  soft_mode,
  input  logic  stop_done,
  input  logic  reset_acc,
  output logic  out_enable,
  output logic  step_enable,
  output logic  soft_stop,
  output logic  hard_stop
);

  logic soft_pend_q;

  always_ff @(posedge clk) begin
    if (rst)                         soft_pend_q <= 1'b0;
    else if (wd_expire && soft_mode) soft_pend_q <= 1'b1;
    else if (stop_done || reset_acc) soft_pend_q <= 1'b0;
  end

  assign out_enable  = (state == ST_ACTIVE);
  assign step_enable = step_gate(state, soft_pend_q);
  assign soft_stop   = soft_pend_q;
  assign hard_stop   = !step_enable;

  AST_HARD_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (wd_expire && !soft_mode) |=> (!step_enable && hard_stop)); // R9
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (soft_stop && !stop_done && !reset_acc) |=> (soft_stop && step_enable)); // R10
  AST_SOFT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (soft_stop && stop_done && !wd_expire) |=> !step_enable); // R10
  AST_SOFT_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (soft_stop && reset_acc) |=> (!soft_stop && hard_stop)); // R11
  AST_SAFE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (state != ST_ACTIVE) |-> !out_enable); // R6

endmodule

// File: rtl/motion_safety_ctrl.sv
module motion_safety_ctrl
  import msc_pkg::*;
#(
  parameter int TMR_W      = 17,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_US = 1500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_header,
  input  logic             cmd_reset,
  input  logic             cmd_pet,
  input  logic             clr_ack,
  input  logic             soft_mode,
  input  logic             stop_done,
  input  logic [TMR_W-1:0] wd_limit,
  output logic [2:0]       state_code,
  output logic             out_enable,
  output logic             step_enable,
  output logic             cnt_clear,
  output logic             hard_stop,
  output logic             soft_stop
);

  localparam int WD_DEFAULT = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  sess_t            state;
  logic             reset_acc;
  logic             enter_active;
  logic             pet_acc;
  logic             wd_expire;
  logic [TMR_W-1:0] wd_count;
  logic [TMR_W-1:0] eff_limit;

  assign eff_limit = TMR_W'(pick_limit(32'(wd_limit), 32'(WD_DEFAULT)));

  msc_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_header   (cmd_header),
    .cmd_reset    (cmd_reset),
    .cmd_pet      (cmd_pet),
    .clr_ack      (clr_ack),
    .wd_expire    (wd_expire),
    .state        (state),
    .cnt_clear    (cnt_clear),
    .reset_acc    (reset_acc),
    .enter_active (enter_active),
    .pet_acc      (pet_acc)
  );

  msc_watchdog #(.TMR_W(TMR_W)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .run    (state == ST_ACTIVE),
    .feed   (pet_acc),
    .limit  (eff_limit),
    .expire (wd_expire),
    .count  (wd_count)
  );

  msc_stop u_stop (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .wd_expire   (wd_expire),
    .soft_mode   (soft_mode),
    .stop_done   (stop_done),
    .reset_acc   (reset_acc),
    .out_enable  (out_enable),
    .step_enable (step_enable),
    .soft_stop   (soft_stop),
    .hard_stop   (hard_stop)
  );

  assign state_code = state;

  AST_EXPIRE_BITES: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> (state_code == 3'd4)); // R7
  AST_ENTRY_FRESH: assert property (@(posedge clk) disable iff (rst)
    enter_active |=> (wd_count == '0)); // R7
  AST_RST_TO_IDLE: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0)); // R12

endmodule

// File: tb/motion_safety_ctrl_tb.sv
module motion_safety_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 17;
  localparam int DEFV       = 7;

  logic          clk = 1'b0;
  logic          rst, cmd_header, cmd_reset, cmd_pet, clr_ack, soft_mode, stop_done;
  logic [TW-1:0] wd_limit;
  logic [2:0]    state_code;
  logic          out_enable, step_enable, cnt_clear, hard_stop, soft_stop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  motion_safety_ctrl #(.TMR_W(TW), .CLK_HZ(1_000_000), .TIMEOUT_US(DEFV)) u_dut (
    .clk(clk), .rst(rst), .cmd_header(cmd_header), .cmd_reset(cmd_reset),
    .cmd_pet(cmd_pet), .clr_ack(clr_ack), .soft_mode(soft_mode), .stop_done(stop_done),
    .wd_limit(wd_limit), .state_code(state_code), .out_enable(out_enable),
    .step_enable(step_enable), .cnt_clear(cnt_clear), .hard_stop(hard_stop),
    .soft_stop(soft_stop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: cmd_header = 1'b1;
      1: cmd_reset  = 1'b1;
      2: cmd_pet    = 1'b1;
      3: clr_ack    = 1'b1;
      default: stop_done = 1'b1;
    endcase
    tick();
    {cmd_header, cmd_reset, cmd_pet, clr_ack, stop_done} = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {cmd_header, cmd_reset, cmd_pet, clr_ack, stop_done} = '0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic to_active();
    strobe(0);
    strobe(1);
    strobe(3);
    strobe(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    wd_limit = TW'(6);
    soft_mode = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1", "state", state_code, 0);
    chk("R1", "out_enable", out_enable, 0);
    chk("R1", "step_enable", step_enable, 0);
    chk("R1", "hard_stop", hard_stop, 1);
    chk("R1", "soft_stop", soft_stop, 0);
    chk("R1", "cnt_clear", cnt_clear, 0);
    // R5 ignored commands in IDLE
    strobe(2); chk("R5", "pet in idle", state_code, 0);
    strobe(1); chk("R5", "reset in idle", state_code, 0);
    chk("R5", "no clear in idle", cnt_clear, 0);
    // R2 forward path
    strobe(0); chk("R2", "header to init", state_code, 1);
    strobe(0); chk("R5", "header in init", state_code, 1);
    strobe(2); chk("R5", "pet in init", state_code, 1);
    strobe(1); chk("R2", "reset to reset", state_code, 2);
    chk("R3", "clear pulse", cnt_clear, 1);
    tick(); chk("R3", "clear one cycle", cnt_clear, 0);
    strobe(2); chk("R4", "pet before ack", state_code, 2);
    strobe(3);
    strobe(1); chk("R3", "re-reset pulse", cnt_clear, 1);
    chk("R3", "re-reset state", state_code, 2);
    tick();
    strobe(2); chk("R4", "ack discarded by re-reset", state_code, 2);
    strobe(3);
    strobe(2); chk("R4", "pet after ack", state_code, 3);
    chk("R6", "out_enable", out_enable, 1);
    chk("R6", "step_enable", step_enable, 1);
    chk("R6", "hard_stop", hard_stop, 0);
    chk("R6", "soft_stop", soft_stop, 0);
    strobe(1); chk("R5", "reset in active", state_code, 3);
    chk("R5", "no clear in active", cnt_clear, 0);
    strobe(0); chk("R5", "header in active", state_code, 3);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R12", "sync reset state", state_code, 0);
    chk("R12", "sync reset outputs", out_enable, 0);

    // Sweep: both stop modes, every small timeout including the default
    for (int mode = 0; mode < 2; mode++) begin
      for (int lim = 0; lim < 7; lim++) begin
        int eff;
        int n;
        eff = (lim == 0) ? DEFV : lim;
        wd_limit = TW'(lim);
        soft_mode = mode[0];
        do_reset();
        to_active();
        chk("R4", "enter active", state_code, 3);
        for (int k = 0; k < 2; k++) begin
          repeat (eff - 1) tick();
          chk("R7", "alive before limit", state_code, 3);
          strobe(2);
        end
        n = 0;
        while (state_code != 3'd4 && n < 30) begin
          tick();
          n++;
        end
        chk("R7", $sformatf("cycles to expiry lim=%0d", lim), n, eff);
        chk("R6", "safe on expiry", out_enable, 0);
        if (mode == 0) begin
          chk("R9", "hard step_enable", step_enable, 0);
          chk("R9", "hard_stop", hard_stop, 1);
          chk("R9", "no soft", soft_stop, 0);
        end else begin
          chk("R10", "soft_stop", soft_stop, 1);
          chk("R10", "enable held", step_enable, 1);
          chk("R10", "no hard yet", hard_stop, 0);
        end
        strobe(2);
        chk("R8", "pet in expired", state_code, 4);
        chk("R8", "outputs stay safe", out_enable, 0);
        if (mode == 1) begin
          tick();
          chk("R10", "soft still held", soft_stop, 1);
          if (lim == 3) begin
            strobe(1);
            chk("R11", "cancel soft_stop", soft_stop, 0);
            chk("R11", "cancel hard_stop", hard_stop, 1);
            chk("R11", "cancel state", state_code, 2);
          end else begin
            strobe(4);
            chk("R10", "released soft_stop", soft_stop, 0);
            chk("R10", "released enable", step_enable, 0);
            chk("R10", "released hard_stop", hard_stop, 1);
            strobe(1);
          end
        end else begin
          strobe(1);
        end
        chk("R8", "reset leaves expired", state_code, 2);
        chk("R3", "clear on rearm", cnt_clear, 1);
        strobe(3);
        strobe(2);
        chk("R8", "resume through reset", state_code, 3);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule